// File: doc/BRIEF.md
# Flash Command Sequencer with Row-Burst Programming

This block sits between a CPU register bus and an abstract non-volatile memory array and turns software writes into timed program and erase operations. Software first writes the byte to its target array address, which latches the address and data into a one-entry buffer. It then writes an operation code to the command register and launches the operation by writing 1 to the launch bit of the status register. The block raises a high-voltage pump enable, pulses an operation strobe carrying kind, address and data toward the array, and holds the operation for a parameterised number of clock cycles. When nothing is active or queued, it reports completion.

While one operation runs, the buffer frees up so that exactly one further command can be queued. Burst programs keep the pump on from one byte to the next. This holds only when the next burst command is already queued before the current one ends and its address lies in the same row. A row is 64 bytes by default, and the address bits below the row boundary pick the byte within the row. Any other successor makes the pump drop for at least one cycle. Sequence mistakes set an access-error flag. Addresses at or above a protect boundary set a protection-violation flag. In both cases the command is dropped.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, buf_empty and cmd_done are 1, and acc_err, prot_err, div_ready, pump_en and op_strobe are 0.
- R2: Until a write to the divider register (reg_sel=0) sets div_ready, a launch sets acc_err and starts no operation.
- R3: acc_err is set and nothing starts in three cases: a command write (reg_sel=1) with no array write since the last launch attempt, a command code of 0, or an array write while a command is queued. The queued command still runs with its original address and data.
- R4: A launch whose latched address is at or above protect_base sets prot_err and starts no operation. The address protect_base-1 is accepted.
- R5: In a status write (reg_sel=2), bit 1 clears acc_err and bit 2 clears prot_err.
- R6: In a status write, bit 0 launches a fully staged command. buf_empty and cmd_done read 0 from the next cycle, and the buffer is not taken before LAUNCH_HOLD cycles have passed.
- R7: Command codes are 1 = byte program, 2 = burst program and 3 = erase. A program or erase pulses op_strobe once with op_kind, op_addr and op_data, and holds pump_en high for exactly PROG_CYC or ERASE_CYC cycles before turning it off.
- R8: A burst whose successor burst is queued before it ends, and lies in the same row (same address bits above bit 5), keeps pump_en high across both operations with no falling edge.
- R9: A burst whose successor lies in another row, and any byte program, turns pump_en off between operations, so each such operation gives one rising edge of pump_en.
- R10: buf_empty returns to 1 when the engine takes the queued command, while the pump is still on. cmd_done is 1 only when no operation is active and nothing is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arr_wr_en | input | 1 | Write to the array address space (latches address and data) |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 divider, 1 command, 2 status |
| bus_addr | input | AW | Array address for array writes |
| bus_wdata | input | DW | Write data |
| protect_base | input | AW | Lowest protected address |
| div_ready | output | 1 | Divider register has been written |
| buf_empty | output | 1 | Command buffer can accept a new command |
| cmd_done | output | 1 | No operation active or queued |
| acc_err | output | 1 | Access error flag |
| prot_err | output | 1 | Protection violation flag |
| pump_en | output | 1 | High-voltage pump enable |
| op_strobe | output | 1 | One-cycle start pulse toward the array |
| op_kind | output | 2 | Operation code of the current operation |
| op_addr | output | AW | Address of the current operation |
| op_data | output | DW | Data of the current operation |

## Verification
The assertions rely on three things about the inputs. protect_base is held steady while commands are in flight. An array write and a register write never arrive in the same cycle. LAUNCH_HOLD is small compared with the checker's saturating counter. The stimulus keeps to all three: protect_base is driven once before reset is released, and each bus access is issued alone by one task that raises a single strobe for one cycle. Burst sequences are queued by polling buf_empty, so each successor is launched well inside the running operation. This is what lets same-row runs prove continuous pump operation, and lets row crossings show exactly one extra rising edge each.

// File: rtl/fcc_pkg.sv
`timescale 1ns/1ps
package fcc_pkg;
   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_PROG  = 2'd1,
      OP_BURST = 2'd2,
      OP_ERASE = 2'd3
   } op_kind_e;

   localparam logic [1:0] SEL_DIV  = 2'd0;
   localparam logic [1:0] SEL_CMD  = 2'd1;
   localparam logic [1:0] SEL_STAT = 2'd2;

   localparam int STAT_LAUNCH  = 0;
   localparam int STAT_CLR_ACC = 1;
   localparam int STAT_CLR_PRV = 2;
endpackage

// File: rtl/fcc_row_cmp.sv
`timescale 1ns/1ps
module fcc_row_cmp #(
   parameter int AW       = 12,
   parameter int ROW_BITS = 6
) (
   input  logic [AW-1:0] addr_a,
   input  logic [AW-1:0] addr_b,
   output logic          same_row
);
   generate
      if (ROW_BITS >= AW) begin : g_one_row
         logic unused_addr;
         assign unused_addr = ^{addr_a, addr_b};
         assign same_row    = 1'b1;
      end else begin : g_cmp
         assign same_row = (addr_a[AW-1:ROW_BITS] == addr_b[AW-1:ROW_BITS]);
      end
   endgenerate
endmodule

// File: rtl/fcc_regs.sv
`timescale 1ns/1ps
module fcc_regs
   import fcc_pkg::*;
#(
   parameter int AW   = 12,
   parameter int DW   = 8,
   parameter int HOLD = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          arr_wr_en,
   input  logic          reg_wr_en,
   input  logic [1:0]    reg_sel,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   input  logic [AW-1:0] protect_base,
   input  logic          take,
   output logic          div_ready,
   output logic          q_valid,
   output logic [1:0]    q_kind,
   output logic [AW-1:0] q_addr,
   output logic [DW-1:0] q_data,
   output logic          hold_busy,
   output logic          acc_err,
   output logic          prot_err
);
   logic have_data, have_cmd, launch_ok;
   logic unused_bits;
   assign unused_bits = ^bus_wdata[DW-1:3];

   assign launch_ok = reg_wr_en && (reg_sel == SEL_STAT) && bus_wdata[STAT_LAUNCH]
                      && !q_valid && div_ready && have_cmd && (q_addr < protect_base);

   generate
      if (HOLD == 0) begin : g_no_hold
         assign hold_busy = 1'b0;
      end else begin : g_hold
         localparam int HW = $clog2(HOLD + 1);
         logic [HW-1:0] hold_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              hold_cnt <= '0;
            else if (launch_ok)      hold_cnt <= HW'(HOLD);
            else if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
         end
         assign hold_busy = (hold_cnt != '0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_ready <= 1'b0;
         q_valid   <= 1'b0;
         q_kind    <= OP_NONE;
         q_addr    <= '0;
         q_data    <= '0;
         have_data <= 1'b0;
         have_cmd  <= 1'b0;
         acc_err   <= 1'b0;
         prot_err  <= 1'b0;
      end else begin
         if (take) q_valid <= 1'b0;
         if (arr_wr_en) begin
            if (q_valid) acc_err <= 1'b1;
            else begin
               q_addr    <= bus_addr;
               q_data    <= bus_wdata;
               have_data <= 1'b1;
               have_cmd  <= 1'b0;
            end
         end
         if (reg_wr_en) begin
            case (reg_sel)
               SEL_DIV: div_ready <= 1'b1;
               SEL_CMD: begin
                  if (q_valid) acc_err <= 1'b1;
                  else if (!have_data || bus_wdata[1:0] == OP_NONE) begin
                     acc_err   <= 1'b1;
                     have_data <= 1'b0;
                     have_cmd  <= 1'b0;
                  end else begin
                     q_kind   <= bus_wdata[1:0];
                     have_cmd <= 1'b1;
                  end
               end
               SEL_STAT: begin
                  if (bus_wdata[STAT_CLR_ACC]) acc_err  <= 1'b0;
                  if (bus_wdata[STAT_CLR_PRV]) prot_err <= 1'b0;
                  if (bus_wdata[STAT_LAUNCH] && !q_valid) begin
                     have_data <= 1'b0;
                     have_cmd  <= 1'b0;
                     if (!div_ready || !have_cmd) acc_err  <= 1'b1;
                     else if (!launch_ok)         prot_err <= 1'b1;
                     else                         q_valid  <= 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/fcc_engine.sv
`timescale 1ns/1ps
module fcc_engine
   import fcc_pkg::*;
#(
   parameter int AW        = 12,
   parameter int DW        = 8,
   parameter int PROG_CYC  = 20,
   parameter int BURST_CYC = 8,
   parameter int ERASE_CYC = 40
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          q_valid,
   input  logic [1:0]    q_kind,
   input  logic [AW-1:0] q_addr,
   input  logic [DW-1:0] q_data,
   input  logic          hold_busy,
   input  logic          same_row,
   output logic          take,
   output logic          pump_en,
   output logic          op_strobe,
   output logic [1:0]    op_kind,
   output logic [AW-1:0] op_addr,
   output logic [DW-1:0] op_data
);
   localparam int MAX_PB = (PROG_CYC > BURST_CYC) ? PROG_CYC : BURST_CYC;
   localparam int MAXC   = (MAX_PB > ERASE_CYC) ? MAX_PB : ERASE_CYC;
   localparam int TW     = $clog2(MAXC + 1);

   logic [TW-1:0] timer;
   logic finish, chain;

   function automatic logic [TW-1:0] dur_of(input logic [1:0] k);
      case (k)
         OP_BURST: dur_of = TW'(BURST_CYC);
         OP_ERASE: dur_of = TW'(ERASE_CYC);
         default:  dur_of = TW'(PROG_CYC);
      endcase
   endfunction

   always_comb begin
      finish = pump_en && (timer == TW'(1));
      chain  = finish && q_valid && (q_kind == OP_BURST) && (op_kind == OP_BURST) && same_row;
      take   = !hold_busy && q_valid && (!pump_en || chain);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pump_en   <= 1'b0;
         op_strobe <= 1'b0;
         op_kind   <= OP_NONE;
         op_addr   <= '0;
         op_data   <= '0;
         timer     <= '0;
      end else begin
         op_strobe <= 1'b0;
         if (take) begin
            pump_en   <= 1'b1;
            op_strobe <= 1'b1;
            op_kind   <= q_kind;
            op_addr   <= q_addr;
            op_data   <= q_data;
            timer     <= dur_of(q_kind);
         end else if (chain) begin
            timer <= timer;
         end else if (finish) begin
            pump_en <= 1'b0;
            timer   <= '0;
         end else if (pump_en) begin
            timer <= timer - 1'b1;
         end
      end
   end
endmodule

// File: rtl/flash_cmd_ctrl.sv
`timescale 1ns/1ps
module flash_cmd_ctrl #(
   parameter int AW          = 12,
   parameter int DW          = 8,
   parameter int ROW_BITS    = 6,
   parameter int PROG_CYC    = 20,
   parameter int BURST_CYC   = 8,
   parameter int ERASE_CYC   = 40,
   parameter int LAUNCH_HOLD = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          arr_wr_en,
   input  logic          reg_wr_en,
   input  logic [1:0]    reg_sel,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   input  logic [AW-1:0] protect_base,
   output logic          div_ready,
   output logic          buf_empty,
   output logic          cmd_done,
   output logic          acc_err,
   output logic          prot_err,
   output logic          pump_en,
   output logic          op_strobe,
   output logic [1:0]    op_kind,
   output logic [AW-1:0] op_addr,
   output logic [DW-1:0] op_data
);
   generate
      if (DW < 3)        begin : g_bad_dw   $error("DW must be at least 3"); end
      if (PROG_CYC < 1)  begin : g_bad_prog $error("PROG_CYC must be positive"); end
      if (BURST_CYC < 1) begin : g_bad_bst  $error("BURST_CYC must be positive"); end
      if (ERASE_CYC < 1) begin : g_bad_ers  $error("ERASE_CYC must be positive"); end
      if (ROW_BITS < 1)  begin : g_bad_row  $error("ROW_BITS must be positive"); end
   endgenerate

   logic          q_valid, hold_busy, take, same_row;
   logic [1:0]    q_kind;
   logic [AW-1:0] q_addr;
   logic [DW-1:0] q_data;

   fcc_regs #(.AW(AW), .DW(DW), .HOLD(LAUNCH_HOLD)) u_regs (
      .clk(clk), .rst_n(rst_n), .arr_wr_en(arr_wr_en), .reg_wr_en(reg_wr_en),
      .reg_sel(reg_sel), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .protect_base(protect_base), .take(take), .div_ready(div_ready),
      .q_valid(q_valid), .q_kind(q_kind), .q_addr(q_addr), .q_data(q_data),
      .hold_busy(hold_busy), .acc_err(acc_err), .prot_err(prot_err)
   );

   fcc_row_cmp #(.AW(AW), .ROW_BITS(ROW_BITS)) u_row (
      .addr_a(q_addr), .addr_b(op_addr), .same_row(same_row)
   );

   fcc_engine #(.AW(AW), .DW(DW), .PROG_CYC(PROG_CYC), .BURST_CYC(BURST_CYC),
                .ERASE_CYC(ERASE_CYC)) u_eng (
      .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_kind(q_kind),
      .q_addr(q_addr), .q_data(q_data), .hold_busy(hold_busy), .same_row(same_row),
      .take(take), .pump_en(pump_en), .op_strobe(op_strobe), .op_kind(op_kind),
      .op_addr(op_addr), .op_data(op_data)
   );

   assign buf_empty = !q_valid;
   assign cmd_done  = !pump_en && !q_valid && !hold_busy;
endmodule

// File: rtl/fcc_checker.sv
`timescale 1ns/1ps
module fcc_checker
   import fcc_pkg::*;
#(
   parameter int AW   = 12,
   parameter int HOLD = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          div_ready,
   input logic          buf_empty,
   input logic          cmd_done,
   input logic          pump_en,
   input logic          op_strobe,
   input logic [1:0]    op_kind,
   input logic [AW-1:0] op_addr,
   input logic [AW-1:0] protect_base
);
   logic [7:0] since_fall;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  since_fall <= 8'd0;
      else if (buf_empty)          since_fall <= 8'd0;
      else if (since_fall != 8'hFF) since_fall <= since_fall + 8'd1;
   end

   AST_STROBE_WITH_PUMP: assert property (@(posedge clk) disable iff (!rst_n)
      op_strobe |-> pump_en);                                        // R7
   AST_DONE_MEANS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_done |-> (!pump_en && buf_empty));                         // R10
   AST_NO_DIV_NO_PUMP: assert property (@(posedge clk) disable iff (!rst_n)
      !div_ready |-> !pump_en);                                      // R2
   AST_PROTECTED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      op_strobe |-> (op_addr < protect_base));                       // R4
   AST_LAUNCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(buf_empty) |-> (since_fall >= 8'(HOLD)));                // R6
   AST_CHAIN_IS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      (op_strobe && $past(pump_en)) |-> (op_kind == OP_BURST));      // R8
endmodule

bind flash_cmd_ctrl fcc_checker #(.AW(AW), .HOLD(LAUNCH_HOLD)) i_fcc_checker (
   .clk(clk), .rst_n(rst_n), .div_ready(div_ready), .buf_empty(buf_empty),
   .cmd_done(cmd_done), .pump_en(pump_en), .op_strobe(op_strobe),
   .op_kind(op_kind), .op_addr(op_addr), .protect_base(protect_base)
);

// File: tb/test_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module test_flash_cmd_ctrl;
   localparam int AW = 12, DW = 8;
   localparam int PROG_CYC = 20, BURST_CYC = 8, ERASE_CYC = 40, HOLD = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic arr_wr_en = 1'b0, reg_wr_en = 1'b0;
   logic [1:0] reg_sel = 2'd0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [AW-1:0] protect_base = 12'hF00;
   logic div_ready, buf_empty, cmd_done, acc_err, prot_err, pump_en, op_strobe;
   logic [1:0] op_kind;
   logic [AW-1:0] op_addr;
   logic [DW-1:0] op_data;

   flash_cmd_ctrl #(.AW(AW), .DW(DW), .ROW_BITS(6), .PROG_CYC(PROG_CYC),
      .BURST_CYC(BURST_CYC), .ERASE_CYC(ERASE_CYC), .LAUNCH_HOLD(HOLD)) i_flash_cmd_ctrl (
      .clk(clk), .rst_n(rst_n), .arr_wr_en(arr_wr_en), .reg_wr_en(reg_wr_en),
      .reg_sel(reg_sel), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .protect_base(protect_base), .div_ready(div_ready), .buf_empty(buf_empty),
      .cmd_done(cmd_done), .acc_err(acc_err), .prot_err(prot_err), .pump_en(pump_en),
      .op_strobe(op_strobe), .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data));

   always #4 clk = ~clk;

   int n_chk = 0, n_fail = 0;
   int rises = 0, hi_cyc = 0, strobes = 0;
   int last_kind = 0, last_addr = 0, last_data = 0;
   logic pump_prev = 1'b0;

   always @(negedge clk) begin
      if (pump_en && !pump_prev) rises++;
      if (pump_en) hi_cyc++;
      if (op_strobe) begin
         strobes++;
         last_kind = int'(op_kind);
         last_addr = int'(op_addr);
         last_data = int'(op_data);
      end
      pump_prev = pump_en;
   end

   // kind[29:28] start[27:16] count[15:8] expected pump rises[7:0]
   localparam logic [29:0] VEC [8] = '{
      {2'd2, 12'h000, 8'd4,   8'd1},
      {2'd2, 12'h03E, 8'd4,   8'd2},
      {2'd2, 12'h07F, 8'd2,   8'd2},
      {2'd2, 12'h100, 8'd64,  8'd1},
      {2'd2, 12'h13C, 8'd10,  8'd2},
      {2'd1, 12'h200, 8'd3,   8'd3},
      {2'd3, 12'h240, 8'd2,   8'd2},
      {2'd2, 12'h2C0, 8'd130, 8'd3}
   };

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic is_arr, input logic [1:0] sel,
                     input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(posedge clk); #1;
      arr_wr_en = is_arr; reg_wr_en = !is_arr; reg_sel = sel; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      arr_wr_en = 1'b0; reg_wr_en = 1'b0;
   endtask

   task automatic issue(input logic [1:0] kind, input logic [AW-1:0] a, input logic [DW-1:0] d);
      while (!buf_empty) @(negedge clk);
      wr(1'b1, 2'd0, a, d);
      wr(1'b0, 2'd1, '0, {6'd0, kind});
      wr(1'b0, 2'd2, '0, 8'h01);
   endtask

   task automatic wait_done();
      @(negedge clk);
      while (!cmd_done) @(negedge clk);
   endtask

   initial begin
      #(200000 * 8);
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      int r0, h0, s0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 buf_empty", int'(buf_empty), 1);
      chk("R1 cmd_done", int'(cmd_done), 1);
      chk("R1 errs/div/pump", int'({acc_err, prot_err, div_ready, pump_en, op_strobe}), 0);

      // R2 launch before divider write
      r0 = rises;
      issue(2'd1, 12'h020, 8'h55);
      repeat (10) @(negedge clk);
      chk("R2 acc_err", int'(acc_err), 1);
      chk("R2 no pump", rises - r0, 0);
      chk("R2 buffer still free", int'(buf_empty), 1);
      // R5 clear access error
      wr(1'b0, 2'd2, '0, 8'h02);
      @(negedge clk);
      chk("R5 acc_err cleared", int'(acc_err), 0);

      wr(1'b0, 2'd0, '0, 8'h13);
      @(negedge clk);
      chk("R2 div_ready", int'(div_ready), 1);

      // R3 command without array write
      wr(1'b0, 2'd1, '0, 8'h01);
      @(negedge clk);
      chk("R3 cmd without data", int'(acc_err), 1);
      wr(1'b0, 2'd2, '0, 8'h02);
      // R3 command code zero
      wr(1'b1, 2'd0, 12'h021, 8'h11);
      wr(1'b0, 2'd1, '0, 8'h00);
      @(negedge clk);
      chk("R3 code zero", int'(acc_err), 1);
      wr(1'b0, 2'd2, '0, 8'h02);
      @(negedge clk);
      chk("R5 acc_err cleared again", int'(acc_err), 0);

      // R6, R10, R7 byte program with launch latency
      r0 = rises; h0 = hi_cyc; s0 = strobes;
      issue(2'd1, 12'h010, 8'hA5);
      @(negedge clk);
      chk("R6 buf_empty low after launch", int'(buf_empty), 0);
      chk("R6 cmd_done low after launch", int'(cmd_done), 0);
      repeat (2) @(negedge clk);
      chk("R6 buffer held during hold", int'(buf_empty), 0);
      repeat (4) @(negedge clk);
      chk("R10 buffer free while pumping", int'({buf_empty, pump_en, cmd_done}), 6);
      wait_done();
      chk("R7 program pump cycles", hi_cyc - h0, PROG_CYC);
      chk("R7 one strobe", strobes - s0, 1);
      chk("R7 kind", last_kind, 1);
      chk("R7 addr", last_addr, 12'h010);
      chk("R7 data", last_data, 8'hA5);
      chk("R9 program one rise", rises - r0, 1);

      // R3 array write while queued is ignored
      issue(2'd1, 12'h030, 8'h3C);
      wr(1'b1, 2'd0, 12'h031, 8'h99);
      wait_done();
      chk("R3 write while queued", int'(acc_err), 1);
      chk("R3 queued addr kept", last_addr, 12'h030);
      chk("R3 queued data kept", last_data, 8'h3C);
      wr(1'b0, 2'd2, '0, 8'h02);

      // R4 protect boundary
      r0 = rises;
      issue(2'd1, 12'hF00, 8'h01);
      repeat (10) @(negedge clk);
      chk("R4 prot_err", int'(prot_err), 1);
      chk("R4 no pump", rises - r0, 0);
      wr(1'b0, 2'd2, '0, 8'h04);
      @(negedge clk);
      chk("R5 prot_err cleared", int'(prot_err), 0);
      issue(2'd1, 12'hEFF, 8'h02);
      wait_done();
      chk("R4 boundary minus one accepted", rises - r0, 1);
      chk("R4 no error", int'(prot_err), 0);

      // R7 erase
      h0 = hi_cyc;
      issue(2'd3, 12'h080, 8'h00);
      wait_done();
      chk("R7 erase pump cycles", hi_cyc - h0, ERASE_CYC);
      chk("R7 erase kind", last_kind, 3);

      // R8 / R9 table of sequences
      for (int v = 0; v < 8; v++) begin
         int cnt;
         logic [1:0] kind;
         logic [AW-1:0] base;
         kind = VEC[v][29:28];
         base = VEC[v][27:16];
         cnt  = int'(VEC[v][15:8]);
         r0 = rises; s0 = strobes;
         for (int i = 0; i < cnt; i++) issue(kind, base + AW'(i), 8'(base) + 8'(i));
         wait_done();
         if (kind == 2'd2) chk($sformatf("R8 R9 burst vec %0d rises", v), rises - r0, int'(VEC[v][7:0]));
         else chk($sformatf("R9 single vec %0d rises", v), rises - r0, int'(VEC[v][7:0]));
         chk($sformatf("R10 vec %0d strobes", v), strobes - s0, cnt);
         chk($sformatf("R3 vec %0d no errors", v), int'({acc_err, prot_err}), 0);
      end

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule